// File: doc/BRIEF.md
# Shared-RAM Multi-FIFO Packet Buffer

This block carves one single-port data RAM of 32-bit words into one receive FIFO and up to four transmit FIFOs. Software places each FIFO by writing a start word and a depth in words. After that, each FIFO runs as its own circular queue inside that region, with private read and write pointers, a fill level, and empty and full flags. FIFO index 0 is the receive FIFO. Index k+1 is transmit FIFO k.

There are two requesters, one access each per cycle. The application side pushes words into a chosen transmit FIFO and pops words from the receive FIFO. The USB side pushes received words into the receive FIFO and pops words from a chosen transmit FIFO. Only one access reaches the RAM in a cycle, and the USB side wins. The RAM enable is raised only in cycles that really read or write a word, so the array toggles only when it is used.

A transmit FIFO works only while its endpoint-active input is high. This lets the set of live transmit queues follow the current role and the IN endpoints in use.

Top module: `shared_fifo_ram`

## Requirements
- R1: After reset every FIFO is unconfigured. Every FIFO shows level 0, empty=1 and full=1, all overflow, underflow and config-error flags are 0, and ram_ce, app_wait and both read-valid outputs are 0.
- R2: A config write is accepted when all three hold: the depth is at least 1, start+depth is at most 320, and the region shares no word with another currently configured FIFO. An accepted write enables the FIFO (index 0 = receive, k+1 = transmit k), clears its config-error flag, and empties it.
- R3: A config write that breaks any rule of R2 sets that FIFO's sticky config-error flag and disables it. A disabled FIFO shows empty=1 and full=1.
- R4: Transmit FIFO k accepts pushes and pops only while tx_act[k] is 1. The receive FIFO needs only a valid configuration.
- R5: Words leave each FIFO in the order they entered. Pointers wrap inside the FIFO's own region, and traffic on one FIFO never alters another FIFO's contents.
- R6: The level output equals the number of stored words. empty=1 when the level is 0, and full=1 when the level equals the depth.
- R7: A push to a full or disabled FIFO, or a pop from an empty or disabled one, is dropped without any RAM access. It sets that FIFO's sticky overflow (push) or underflow (pop) flag.
- R8: A flush pulse empties its FIFO and clears its overflow and underflow flags. The configuration is kept.
- R9: When the USB side makes an access in a cycle, a pending application request in that cycle is not performed and app_wait is 1. The application retries in a later cycle.
- R10: An accepted pop returns its word on the matching rdata output, with its read-valid high, in the cycle after the access.
- R11: ram_ce is 1 exactly in the cycles where a word is written to or read from the RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | FIFO index being configured (0 = receive) |
| cfg_base | input | 9 | Region start word |
| cfg_depth | input | 9 | Region depth in words |
| tx_act | input | 4 | Endpoint-active enable per transmit FIFO |
| flush | input | 5 | Per-FIFO flush pulse |
| app_req | input | 1 | Application access request |
| app_wr | input | 1 | 1 = push to transmit FIFO, 0 = pop receive FIFO |
| app_sel | input | 2 | Transmit FIFO number for a push |
| app_wdata | input | 32 | Application push data |
| app_wait | output | 1 | Application request stalled by the USB side |
| app_rvalid | output | 1 | Application pop data valid |
| app_rdata | output | 32 | Application pop data |
| usb_req | input | 1 | USB access request |
| usb_wr | input | 1 | 1 = push to receive FIFO, 0 = pop transmit FIFO |
| usb_sel | input | 2 | Transmit FIFO number for a pop |
| usb_wdata | input | 32 | USB push data |
| usb_rvalid | output | 1 | USB pop data valid |
| usb_rdata | output | 32 | USB pop data |
| lvl | output | 45 | Packed 9-bit fill level per FIFO, FIFO 0 in the low bits |
| empty | output | 5 | Per-FIFO empty flag |
| full | output | 5 | Per-FIFO full flag |
| ovf | output | 5 | Per-FIFO sticky overflow flag |
| udf | output | 5 | Per-FIFO sticky underflow flag |
| cfg_err | output | 5 | Per-FIFO sticky config-error flag |
| ram_ce | output | 1 | RAM enable for this cycle |

## Verification
The assertions rely on a few conditions being true of the inputs:
- Reset is applied before any traffic.
- cfg_sel is below the FIFO count.
- The selectors only name transmit FIFOs that exist.
- Config writes come in cycles with no access request.

The stimulus keeps to these conditions. Selectors are drawn only from the transmit range, and config writes run in dedicated idle cycles. Random requests, flushes and changes to the endpoint-active mask then move freely across full, empty, wrapped and disabled FIFOs.

// File: rtl/pbuf_pkg.sv
package pbuf_pkg;

   localparam int unsigned PBUF_MAX_TX = 4;

   // true when [a_base, a_base+a_len) and [b_base, b_base+b_len) share a word
   function automatic logic spans_overlap(input logic [31:0] a_base,
                                          input logic [31:0] a_len,
                                          input logic [31:0] b_base,
                                          input logic [31:0] b_len);
      return (a_base < b_base + b_len) && (b_base < a_base + a_len);
   endfunction

endpackage

// File: rtl/pbuf_ram.sv
module pbuf_ram #(
   parameter int DW    = 32,
   parameter int WORDS = 320,
   parameter int AW    = $clog2(WORDS)
) (
   input  logic          clk,
   input  logic          ce,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);

   logic [DW-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (ce) begin
         if (we) mem[addr] <= wdata;
         else    rdata     <= mem[addr];
      end
   end

   // R5: every access the controller issues lands inside the array
   p_addr_in_range_r5: assert property (@(posedge clk) ce |-> (32'(addr) < 32'(WORDS)))
      else $error("RAM address out of range");

endmodule

// File: rtl/pbuf_region_chk.sv
module pbuf_region_chk #(
   parameter int RAM_WORDS = 320,
   parameter int NF        = 5,
   parameter int LW        = 9,
   parameter int SW        = 3
) (
   input  logic [SW-1:0] sel,
   input  logic [LW-1:0] base,
   input  logic [LW-1:0] depth,
   input  logic [LW-1:0] r_base  [NF],
   input  logic [LW-1:0] r_depth [NF],
   input  logic [NF-1:0] r_ok,
   output logic          good
);

   logic [NF-1:0] clash;

   for (genvar j = 0; j < NF; j++) begin : g_cmp
      assign clash[j] = r_ok[j] && (sel != SW'(j)) &&
                        pbuf_pkg::spans_overlap(32'(base), 32'(depth),
                                                32'(r_base[j]), 32'(r_depth[j]));
   end

   always_comb begin
      good = (depth != '0) &&
             (32'(base) + 32'(depth) <= 32'(RAM_WORDS)) &&
             (clash == '0);
   end

endmodule

// File: rtl/pbuf_fifo_ctl.sv
module pbuf_fifo_ctl #(
   parameter int AW = 9,
   parameter int LW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_wr,
   input  logic          cfg_good,
   input  logic [LW-1:0] cfg_base,
   input  logic [LW-1:0] cfg_depth,
   input  logic          act,
   input  logic          flush,
   input  logic          push,
   input  logic          pop,
   input  logic          push_bad,
   input  logic          pop_bad,
   output logic [LW-1:0] base_o,
   output logic [LW-1:0] depth_o,
   output logic          ok_o,
   output logic [AW-1:0] wr_addr,
   output logic [AW-1:0] rd_addr,
   output logic [LW-1:0] level,
   output logic          empty,
   output logic          full,
   output logic          ovf,
   output logic          udf,
   output logic          err
);

   logic [LW-1:0] wptr, rptr;
   logic          en;

   function automatic logic [LW-1:0] bump(input logic [LW-1:0] p,
                                           input logic [LW-1:0] d);
      return (p == d - LW'(1)) ? '0 : p + LW'(1);
   endfunction

   always_comb begin
      en      = ok_o && act;
      empty   = !en || (level == '0);
      full    = !en || (level == depth_o);
      wr_addr = AW'(base_o + wptr);
      rd_addr = AW'(base_o + rptr);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_o  <= '0;
         depth_o <= '0;
         ok_o    <= 1'b0;
         err     <= 1'b0;
         wptr    <= '0;
         rptr    <= '0;
         level   <= '0;
         ovf     <= 1'b0;
         udf     <= 1'b0;
      end else if (cfg_wr) begin
         wptr  <= '0;
         rptr  <= '0;
         level <= '0;
         ovf   <= 1'b0;
         udf   <= 1'b0;
         if (cfg_good) begin
            base_o  <= cfg_base;
            depth_o <= cfg_depth;
            ok_o    <= 1'b1;
            err     <= 1'b0;
         end else begin
            ok_o <= 1'b0;
            err  <= 1'b1;
         end
      end else if (flush) begin
         wptr  <= '0;
         rptr  <= '0;
         level <= '0;
         ovf   <= 1'b0;
         udf   <= 1'b0;
      end else begin
         if (push) begin
            wptr  <= bump(wptr, depth_o);
            level <= level + LW'(1);
         end else if (pop) begin
            rptr  <= bump(rptr, depth_o);
            level <= level - LW'(1);
         end
         if (push_bad) ovf <= 1'b1;
         if (pop_bad)  udf <= 1'b1;
      end
   end

   p_level_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ok_o |-> (level <= depth_o))
      else $error("level exceeds depth");

   p_push_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full)
      else $error("push committed into full FIFO");

   p_pop_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty)
      else $error("pop committed from empty FIFO");

   p_push_grows_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !cfg_wr && !flush) |=> (level == $past(level) + LW'(1)))
      else $error("level did not grow on push");

   p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && !cfg_wr) |=> (level == '0 && !ovf && !udf))
      else $error("flush left state behind");

   p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !flush && !cfg_wr) |=> ovf)
      else $error("overflow flag lost");

   p_bad_cfg_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && !cfg_good) |=> (err && !ok_o))
      else $error("bad config accepted");

endmodule

// File: rtl/pbuf_port_arb.sv
module pbuf_port_arb #(
   parameter int NF = 5,
   parameter int SW = 3
) (
   input  logic          usb_req,
   input  logic          usb_wr,
   input  logic [SW-1:0] usb_f,
   input  logic          app_req,
   input  logic          app_wr,
   input  logic [SW-1:0] app_f,
   input  logic [NF-1:0] empty,
   input  logic [NF-1:0] full,
   output logic          usb_go,
   output logic          usb_bad,
   output logic          app_go,
   output logic          app_bad,
   output logic          app_wait
);

   logic usb_legal, app_legal;

   always_comb begin
      usb_legal = usb_wr ? !full[usb_f] : !empty[usb_f];
      app_legal = app_wr ? !full[app_f] : !empty[app_f];
      usb_go    = usb_req && usb_legal;
      usb_bad   = usb_req && !usb_legal;
      app_wait  = app_req && usb_go;
      app_go    = app_req && !usb_go && app_legal;
      app_bad   = app_req && !usb_go && !app_legal;
   end

endmodule

// File: rtl/shared_fifo_ram.sv
module shared_fifo_ram #(
   parameter int DW        = 32,
   parameter int RAM_WORDS = 320,
   parameter int N_TX      = 4,
   localparam int NF       = N_TX + 1,
   localparam int AW       = $clog2(RAM_WORDS),
   localparam int LW       = $clog2(RAM_WORDS + 1),
   localparam int SW       = $clog2(NF),
   localparam int TSW      = $clog2(N_TX)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [SW-1:0]    cfg_sel,
   input  logic [AW-1:0]    cfg_base,
   input  logic [LW-1:0]    cfg_depth,
   input  logic [N_TX-1:0]  tx_act,
   input  logic [NF-1:0]    flush,
   input  logic             app_req,
   input  logic             app_wr,
   input  logic [TSW-1:0]   app_sel,
   input  logic [DW-1:0]    app_wdata,
   output logic             app_wait,
   output logic             app_rvalid,
   output logic [DW-1:0]    app_rdata,
   input  logic             usb_req,
   input  logic             usb_wr,
   input  logic [TSW-1:0]   usb_sel,
   input  logic [DW-1:0]    usb_wdata,
   output logic             usb_rvalid,
   output logic [DW-1:0]    usb_rdata,
   output logic [NF*LW-1:0] lvl,
   output logic [NF-1:0]    empty,
   output logic [NF-1:0]    full,
   output logic [NF-1:0]    ovf,
   output logic [NF-1:0]    udf,
   output logic [NF-1:0]    cfg_err,
   output logic             ram_ce
);

   if (N_TX < 2 || N_TX > int'(pbuf_pkg::PBUF_MAX_TX)) begin : g_bad_ntx
      $error("N_TX must lie between 2 and PBUF_MAX_TX");
   end
   if (RAM_WORDS < NF) begin : g_bad_words
      $error("RAM_WORDS must hold at least one word per FIFO");
   end
   if (DW < 1) begin : g_bad_dw
      $error("DW must be positive");
   end

   logic [LW-1:0] r_base  [NF];
   logic [LW-1:0] r_depth [NF];
   logic [NF-1:0] r_ok;
   logic [AW-1:0] wr_a    [NF];
   logic [AW-1:0] rd_a    [NF];
   logic [LW-1:0] level_a [NF];
   logic [NF-1:0] push, pop, push_bad, pop_bad, act;

   logic          cfg_good;
   logic [SW-1:0] usb_f, app_f;
   logic          usb_go, usb_bad, app_go, app_bad;
   logic [AW-1:0] usb_addr, app_addr, ram_addr;
   logic          ram_we;
   logic [DW-1:0] ram_wdata, ram_q;

   // ---------------- FIFO index decode ----------------
   always_comb begin
      usb_f = usb_wr ? '0 : SW'(usb_sel) + SW'(1);
      app_f = app_wr ? SW'(app_sel) + SW'(1) : '0;
   end

   pbuf_region_chk #(.RAM_WORDS(RAM_WORDS), .NF(NF), .LW(LW), .SW(SW)) u_chk (
      .sel    (cfg_sel),
      .base   (LW'(cfg_base)),
      .depth  (cfg_depth),
      .r_base (r_base),
      .r_depth(r_depth),
      .r_ok   (r_ok),
      .good   (cfg_good)
   );

   pbuf_port_arb #(.NF(NF), .SW(SW)) u_arb (
      .usb_req (usb_req),
      .usb_wr  (usb_wr),
      .usb_f   (usb_f),
      .app_req (app_req),
      .app_wr  (app_wr),
      .app_f   (app_f),
      .empty   (empty),
      .full    (full),
      .usb_go  (usb_go),
      .usb_bad (usb_bad),
      .app_go  (app_go),
      .app_bad (app_bad),
      .app_wait(app_wait)
   );

   // ---------------- per-FIFO controllers ----------------
   for (genvar f = 0; f < NF; f++) begin : g_fifo
      logic hit_u, hit_a;
      assign hit_u = (usb_f == SW'(f));
      assign hit_a = (app_f == SW'(f));
      if (f == 0) begin : g_rx
         assign act[f] = 1'b1;
      end else begin : g_tx
         assign act[f] = tx_act[f-1];
      end
      assign push[f]     = (usb_go && usb_wr && hit_u) || (app_go && app_wr && hit_a);
      assign pop[f]      = (usb_go && !usb_wr && hit_u) || (app_go && !app_wr && hit_a);
      assign push_bad[f] = (usb_bad && usb_wr && hit_u) || (app_bad && app_wr && hit_a);
      assign pop_bad[f]  = (usb_bad && !usb_wr && hit_u) || (app_bad && !app_wr && hit_a);

      pbuf_fifo_ctl #(.AW(AW), .LW(LW)) u_fifo (
         .clk      (clk),
         .rst_n    (rst_n),
         .cfg_wr   (cfg_we && (cfg_sel == SW'(f))),
         .cfg_good (cfg_good),
         .cfg_base (LW'(cfg_base)),
         .cfg_depth(cfg_depth),
         .act      (act[f]),
         .flush    (flush[f]),
         .push     (push[f]),
         .pop      (pop[f]),
         .push_bad (push_bad[f]),
         .pop_bad  (pop_bad[f]),
         .base_o   (r_base[f]),
         .depth_o  (r_depth[f]),
         .ok_o     (r_ok[f]),
         .wr_addr  (wr_a[f]),
         .rd_addr  (rd_a[f]),
         .level    (level_a[f]),
         .empty    (empty[f]),
         .full     (full[f]),
         .ovf      (ovf[f]),
         .udf      (udf[f]),
         .err      (cfg_err[f])
      );

      assign lvl[f*LW +: LW] = level_a[f];
   end

   // ---------------- RAM port mux ----------------
   always_comb begin
      usb_addr = '0;
      app_addr = '0;
      for (int f = 0; f < NF; f++) begin
         if (usb_f == SW'(f)) usb_addr = usb_wr ? wr_a[f] : rd_a[f];
         if (app_f == SW'(f)) app_addr = app_wr ? wr_a[f] : rd_a[f];
      end
      ram_ce    = usb_go || app_go;
      ram_addr  = usb_go ? usb_addr  : app_addr;
      ram_we    = usb_go ? usb_wr    : app_wr;
      ram_wdata = usb_go ? usb_wdata : app_wdata;
   end

   pbuf_ram #(.DW(DW), .WORDS(RAM_WORDS), .AW(AW)) u_ram (
      .clk  (clk),
      .ce   (ram_ce),
      .we   (ram_we),
      .addr (ram_addr),
      .wdata(ram_wdata),
      .rdata(ram_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         usb_rvalid <= 1'b0;
         app_rvalid <= 1'b0;
      end else begin
         usb_rvalid <= usb_go && !usb_wr;
         app_rvalid <= app_go && !app_wr;
      end
   end

   assign usb_rdata = ram_q;
   assign app_rdata = ram_q;

   p_wait_no_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
      app_wait |=> !app_rvalid)
      else $error("stalled application access produced data");

   p_rvalid_follows_ce_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (app_rvalid || usb_rvalid) |-> $past(ram_ce))
      else $error("read valid without RAM access");

   p_one_reader_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(app_rvalid && usb_rvalid))
      else $error("two readers in one cycle");

   p_ce_needs_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ram_ce |-> (usb_req || app_req))
      else $error("RAM enabled with no request");

   p_cfg_err_disables_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_err != '0) |-> ((cfg_err & empty & full) == cfg_err))
      else $error("errored FIFO still usable");

endmodule

// File: tb/tb_shared_fifo_ram.sv
`timescale 1ns/1ps
module tb_shared_fifo_ram;

   localparam int DW = 32, RW = 320, NT = 4;
   localparam int NF = NT + 1;
   localparam int AW = $clog2(RW), LW = $clog2(RW + 1), SW = $clog2(NF), TSW = $clog2(NT);

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_we = 0; logic [SW-1:0] cfg_sel = '0; logic [AW-1:0] cfg_base = '0; logic [LW-1:0] cfg_depth = '0;
   logic [NT-1:0] tx_act = '0; logic [NF-1:0] flush = '0;
   logic app_req = 0, app_wr = 0; logic [TSW-1:0] app_sel = '0; logic [DW-1:0] app_wdata = '0;
   logic app_wait, app_rvalid; logic [DW-1:0] app_rdata;
   logic usb_req = 0, usb_wr = 0; logic [TSW-1:0] usb_sel = '0; logic [DW-1:0] usb_wdata = '0;
   logic usb_rvalid; logic [DW-1:0] usb_rdata;
   logic [NF*LW-1:0] lvl; logic [NF-1:0] empty, full, ovf, udf, cfg_err; logic ram_ce;

   shared_fifo_ram #(.DW(DW), .RAM_WORDS(RW), .N_TX(NT)) dut (.*);

   always #2.5 clk = ~clk;

   int n_chk = 0, n_err = 0;
   bit done = 0;

   int unsigned m_base[NF], m_depth[NF];
   bit m_ok[NF], m_err[NF], m_ovf[NF], m_udf[NF];
   logic [DW-1:0] mq [NF][$];

   task automatic chk(input string tag, input string what, input longint act_v, input longint exp_v);
      n_chk++;
      if (act_v != exp_v) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act_v, exp_v);
      end
   endtask

   function automatic bit m_en(input int f);
      return m_ok[f] && (f == 0 || tx_act[f-1]);
   endfunction
   function automatic bit m_full(input int f);
      return !m_en(f) || mq[f].size() == m_depth[f];
   endfunction
   function automatic bit m_empty(input int f);
      return !m_en(f) || mq[f].size() == 0;
   endfunction
   function automatic bit m_good(input int f, input int unsigned b, input int unsigned d);
      if (d == 0 || b + d > RW) return 0;
      for (int j = 0; j < NF; j++)
         if (j != f && m_ok[j] && b < m_base[j] + m_depth[j] && m_base[j] < b + d) return 0;
      return 1;
   endfunction

   task automatic check_all(input string tag);
      for (int f = 0; f < NF; f++) begin
         chk("R6", $sformatf("%s level[%0d]", tag, f), lvl[f*LW +: LW], mq[f].size());
         chk("R6", $sformatf("%s empty[%0d]", tag, f), empty[f], m_empty(f));
         chk("R6", $sformatf("%s full[%0d]", tag, f), full[f], m_full(f));
         chk("R7", $sformatf("%s ovf[%0d]", tag, f), ovf[f], m_ovf[f]);
         chk("R7", $sformatf("%s udf[%0d]", tag, f), udf[f], m_udf[f]);
         chk("R3", $sformatf("%s cfg_err[%0d]", tag, f), cfg_err[f], m_err[f]);
      end
   endtask

   task automatic cfg_write(input int f, input int unsigned b, input int unsigned d, input string tag);
      bit g;
      g = m_good(f, b, d);
      cfg_we = 1; cfg_sel = SW'(f); cfg_base = AW'(b); cfg_depth = LW'(d);
      @(posedge clk); @(negedge clk);
      cfg_we = 0;
      mq[f].delete(); m_ovf[f] = 0; m_udf[f] = 0;
      if (g) begin m_ok[f] = 1; m_err[f] = 0; m_base[f] = b; m_depth[f] = d; end
      else begin m_ok[f] = 0; m_err[f] = 1; end
      check_all(tag);
   endtask

   task automatic do_cycle(input bit ureq, input bit uwr, input int usel, input logic [DW-1:0] ud,
                           input bit areq, input bit awr, input int asel, input logic [DW-1:0] ad,
                           input logic [NF-1:0] fl, input string tag);
      int uf, af; bit ugo, ago, ubad, abad, urv, arv; logic [DW-1:0] ue, ae;
      usb_req = ureq; usb_wr = uwr; usb_sel = TSW'(usel); usb_wdata = ud;
      app_req = areq; app_wr = awr; app_sel = TSW'(asel); app_wdata = ad; flush = fl;
      uf = uwr ? 0 : usel + 1;
      af = awr ? asel + 1 : 0;
      ugo  = ureq && (uwr ? !m_full(uf) : !m_empty(uf));
      ubad = ureq && !ugo;
      ago  = areq && !ugo && (awr ? !m_full(af) : !m_empty(af));
      abad = areq && !ugo && !ago;
      #1;
      chk("R9", {tag, " app_wait"}, app_wait, areq && ugo);
      chk("R11", {tag, " ram_ce"}, ram_ce, ugo || ago);
      urv = 0; arv = 0; ue = '0; ae = '0;
      if (ugo) begin
         if (uwr) mq[0].push_back(ud); else begin ue = mq[uf].pop_front(); urv = 1; end
      end
      if (ago) begin
         if (awr) mq[af].push_back(ad); else begin ae = mq[0].pop_front(); arv = 1; end
      end
      if (ubad) begin if (uwr) m_ovf[uf] = 1; else m_udf[uf] = 1; end
      if (abad) begin if (awr) m_ovf[af] = 1; else m_udf[af] = 1; end
      for (int f = 0; f < NF; f++)
         if (fl[f]) begin mq[f].delete(); m_ovf[f] = 0; m_udf[f] = 0; end
      @(posedge clk); @(negedge clk);
      chk("R10", {tag, " usb_rvalid"}, usb_rvalid, urv);
      chk("R10", {tag, " app_rvalid"}, app_rvalid, arv);
      if (urv) chk("R5", {tag, " usb_rdata"}, usb_rdata, ue);
      if (arv) chk("R5", {tag, " app_rdata"}, app_rdata, ae);
      usb_req = 0; app_req = 0; flush = '0;
      check_all(tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (4) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      check_all("R1 reset");
      chk("R1", "ram_ce", ram_ce, 0);
      chk("R1", "app_wait", app_wait, 0);
      chk("R1", "rvalid", usb_rvalid | app_rvalid, 0);
      rst_n = 1;
      @(negedge clk);
      tx_act = '1;
      // R2: valid layout, last region ends exactly at the top word
      cfg_write(0, 0, 40, "R2 rx");
      cfg_write(1, 40, 20, "R2 tx0");
      cfg_write(2, 60, 5, "R2 tx1");
      cfg_write(3, 65, 250, "R2 tx2");
      cfg_write(4, 315, 5, "R2 tx3");
      chk("R2", "tx3 enabled", empty[4] && !full[4], 1);
      // R3: overlap, past the end, zero depth
      cfg_write(4, 310, 10, "R3 overlap");
      chk("R3", "overlap err", cfg_err[4], 1);
      cfg_write(4, 316, 5, "R3 past end");
      cfg_write(4, 316, 0, "R3 zero depth");
      cfg_write(4, 315, 5, "R2 reconfig");
      chk("R2", "err cleared", cfg_err[4], 0);
      // R4: inactive endpoint drops the push
      tx_act = 4'b0111;
      do_cycle(0, 0, 0, 0, 1, 1, 3, 32'h55, '0, "R4 inactive push");
      chk("R4", "ovf on inactive", ovf[4], 1);
      tx_act = '1;
      do_cycle(0, 0, 0, 0, 1, 1, 3, 32'h66, '0, "R4 active push");
      // R6/R7: fill tx1 past full, then drain past empty
      for (int i = 0; i < 6; i++) do_cycle(0, 0, 0, 0, 1, 1, 1, 32'(100 + i), '0, "R7 fill");
      chk("R6", "tx1 full", full[2], 1);
      for (int i = 0; i < 6; i++) do_cycle(1, 0, 1, 0, 0, 0, 0, 0, '0, "R5 drain");
      chk("R7", "tx1 udf", udf[2], 1);
      // R9: simultaneous requests
      do_cycle(1, 1, 0, 32'hABCD, 1, 1, 0, 32'h1234, '0, "R9 clash");
      do_cycle(0, 0, 0, 0, 1, 1, 0, 32'h1234, '0, "R9 retry");
      do_cycle(0, 0, 0, 0, 1, 0, 0, 0, '0, "R10 rx pop");
      // R8: flush keeps config
      do_cycle(0, 0, 0, 0, 1, 1, 0, 32'h77, '0, "R8 prep");
      do_cycle(0, 0, 0, 0, 0, 0, 0, 0, 5'b00010, "R8 flush");
      chk("R8", "tx0 level after flush", lvl[LW +: LW], 0);
      do_cycle(0, 0, 0, 0, 1, 1, 0, 32'h88, '0, "R8 reuse");
      do_cycle(1, 0, 0, 0, 0, 0, 0, 0, '0, "R8 reuse pop");
      // random traffic
      for (int c = 0; c < 20000; c++) begin
         logic [NF-1:0] fl;
         fl = '0;
         if ($urandom_range(199) == 0) fl[$urandom_range(NF - 1)] = 1'b1;
         if ($urandom_range(499) == 0) tx_act = NT'($urandom);
         if ($urandom_range(999) == 0) tx_act = '1;
         do_cycle($urandom_range(1), $urandom_range(1), $urandom_range(NT - 1), $urandom,
                  $urandom_range(1), $urandom_range(1), $urandom_range(NT - 1), $urandom,
                  fl, "R5 random");
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule